// File: doc/BRIEF.md
# Sliding 5x5 Window Feeder with Rotating Weight Bank

This block feeds a dot-product engine with one 5x5 input window and the 25 weights that go with it on every clock. A row sweep begins with a start request. The block then reads five column words from the feature-map storage, one per cycle, and after that produces one window per cycle. At each step the window moves one column to the right. The storage is read once per step, and only the column that enters the window is fetched. Consecutive column words lie 5 addresses apart.

The window is held in five physical column slots, used as a ring. The entering column overwrites the slot of the oldest column, and the other four slots keep their values, so their wires do not toggle. The inputs are never reordered. Instead, the weight bank, a ring of five column shift registers, rotates by one slot at each step. Weight slot p therefore always holds the weight column that belongs to the input column in slot p. The slot that holds the leftmost (oldest) column is shown on an output, so the consumer can recover the logical order if it needs it. At every row start the bank is reloaded in its initial order from a stored copy of the weights, which is written through a separate load port.

A strobe marks the last window of a row. A second strobe marks the last window of a frame when the row was started as the final one. A start that arrives in that last-window cycle chains the next row without an idle cycle.

Top module: `sweep_feeder`

## Requirements
- R1: After reset, win_valid, fm_rd_en, row_done and frame_done are all 0.
- R2: A start is accepted when the block is idle. In the K=5 cycles that follow the accepting edge, fm_rd_en is 1 and win_valid is 0. The first window is valid in the cycle after the fifth read.
- R3: Each read asserts fm_rd_en for one cycle. The first address of a row is row_base, and every following read of that row adds 5. A row makes exactly row_len reads, with row_len of at least 5.
- R4: A row yields row_len-4 valid windows on consecutive cycles, with window offsets c0 = 0, 1, 2 and so on. For each window, win_head equals c0 mod 5. Slot p of win_bus (bits [(p*5+i)*DW +: DW] for row i) holds row i of band column c0 + ((p - win_head) mod 5). Row i of a column word sits at bits [i*DW +: DW] of fm_rd_data.
- R5: From one window to the next within a row, every slot of win_bus other than the previous win_head slot keeps its value.
- R6: Slot p of wt_bus (bits [(p*5+i)*WW +: WW]) holds row i of weight column (p - win_head) mod 5. The weights are those stored when the row's start was accepted. Weight column j is written with wt_wr_col = j, and row i sits at bits [i*WW +: WW] of wt_wr_data.
- R7: Weight writes during a row do not change wt_bus for that row. They take effect from the next accepted start.
- R8: A start while a row is being loaded or swept, other than in its last-window cycle, is ignored. No read takes place at its row_base, and the current row continues unchanged.
- R9: row_done is 1 exactly in the cycle of a row's final window. frame_done is 1 in that same cycle if last_row was 1 when the row's start was accepted. Both are 0 in every other cycle.
- R10: A start in the cycle where row_done is 1 is accepted. The first read of the new row happens in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a row sweep |
| row_base | input | AW | Address of the first column word of the row |
| row_len | input | LW | Number of columns in the row (at least 5) |
| last_row | input | 1 | Marks the requested row as the last one of a frame |
| fm_rd_en | output | 1 | Feature-map read strobe |
| fm_rd_addr | output | AW | Feature-map column address |
| fm_rd_data | input | 5*DW | Column word returned in the same cycle |
| wt_wr_en | input | 1 | Write strobe for the stored weight set |
| wt_wr_col | input | 3 | Weight column index to write |
| wt_wr_data | input | 5*WW | Weight column word |
| win_valid | output | 1 | A window and its weights are presented |
| win_head | output | 3 | Physical slot holding the leftmost window column |
| win_bus | output | 25*DW | Window, five physical column slots |
| wt_bus | output | 25*WW | Weights aligned to the window slots |
| row_done | output | 1 | Final window of the row |
| frame_done | output | 1 | Final window of the last row of a frame |

## Verification
The last window of a row and the acceptance of the next row's start can fall in the same cycle. In that cycle the weight bank is restored from the stored set, while the window still shows the old row and its rotated weights. The bench waits for row_done at a falling edge and raises start in that same cycle. It then expects a read at the new row_base in the next cycle, the old row's final window to have been scored intact, and the new row to appear with the weight set current at that edge. Weight writes and a spurious start placed in the middle of a row check that neither one disturbs the row in flight.

// File: rtl/sweep_feeder_pkg.sv
package sweep_feeder_pkg;
    localparam int K  = 5;
    localparam int PW = $clog2(K);

    typedef logic [PW-1:0] slot_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_RUN
    } sweep_state_e;

    function automatic slot_t slot_next(input slot_t s);
        return (s == slot_t'(K - 1)) ? '0 : s + slot_t'(1);
    endfunction
endpackage

// File: rtl/feeder_ctrl.sv
module feeder_ctrl import sweep_feeder_pkg::*; #(
    parameter int AW   = 12,
    parameter int LW   = 8,
    parameter int STEP = K
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] row_base,
    input  logic [LW-1:0] row_len,
    input  logic          last_row,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output slot_t         ptr,
    output logic          load_en,
    output logic          rot_en,
    output logic          restore,
    output logic          valid,
    output logic          row_done,
    output logic          frame_done
);
    sweep_state_e  st_q;
    logic [LW-1:0] col_q, len_q;
    logic [AW-1:0] addr_q;
    slot_t         ptr_q;
    logic          last_q;
    logic          more;
    logic          accept;

    always_comb begin
        more       = (col_q < len_q);
        load_en    = (st_q == ST_FILL) || ((st_q == ST_RUN) && more);
        rot_en     = (st_q == ST_RUN) && more;
        valid      = (st_q == ST_RUN);
        row_done   = (st_q == ST_RUN) && !more;
        frame_done = row_done && last_q;
        accept     = start && ((st_q == ST_IDLE) || row_done);
        restore    = accept;
        rd_en      = load_en;
        rd_addr    = addr_q;
        ptr        = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            col_q  <= '0;
            len_q  <= '0;
            addr_q <= '0;
            ptr_q  <= '0;
            last_q <= 1'b0;
        end else if (accept) begin
            st_q   <= ST_FILL;
            col_q  <= '0;
            len_q  <= row_len;
            addr_q <= row_base;
            ptr_q  <= '0;
            last_q <= last_row;
        end else if (load_en) begin
            col_q  <= col_q + LW'(1);
            addr_q <= addr_q + AW'(STEP);
            ptr_q  <= slot_next(ptr_q);
            if (st_q == ST_FILL && col_q == LW'(K - 1))
                st_q <= ST_RUN;
        end else if (st_q == ST_RUN) begin
            st_q <= ST_IDLE;
        end
    end

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(STEP)))
        else $error("p_addr_step_r3");

    p_done_in_window_r9: assert property (@(posedge clk) disable iff (rst)
        (row_done || frame_done) |-> valid)
        else $error("p_done_in_window_r9");

    p_chain_read_r10: assert property (@(posedge clk) disable iff (rst)
        (row_done && start) |=> (rd_en && rd_addr == $past(row_base)))
        else $error("p_chain_read_r10");
endmodule

// File: rtl/feeder_window.sv
module feeder_window import sweep_feeder_pkg::*; #(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  slot_t             load_slot,
    input  logic [K*DW-1:0]   col_data,
    output logic [K*K*DW-1:0] win_bus
);
    logic [K*DW-1:0] slot_q [K];

    for (genvar p = 0; p < K; p++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[p] <= '0;
            else if (load_en && load_slot == slot_t'(p))
                slot_q[p] <= col_data;
        end

        assign win_bus[p*K*DW +: K*DW] = slot_q[p];

        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            ($past(load_en) && $past(load_slot) != slot_t'(p)) |->
                (win_bus[p*K*DW +: K*DW] == $past(win_bus[p*K*DW +: K*DW])))
            else $error("p_hold_r5");

        p_capture_r4: assert property (@(posedge clk) disable iff (rst)
            ($past(load_en) && $past(load_slot) == slot_t'(p)) |->
                (win_bus[p*K*DW +: K*DW] == $past(col_data)))
            else $error("p_capture_r4");
    end
endmodule

// File: rtl/feeder_wbank.sv
module feeder_wbank import sweep_feeder_pkg::*; #(
    parameter int WW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  slot_t             wr_col,
    input  logic [K*WW-1:0]   wr_data,
    input  logic              restore,
    input  logic              rot_en,
    output logic [K*K*WW-1:0] wt_bus
);
    logic [K*WW-1:0] base_q [K];
    logic [K*WW-1:0] bank_q [K];

    for (genvar p = 0; p < K; p++) begin : g_col
        localparam int PV = (p + K - 1) % K;

        always_ff @(posedge clk) begin
            if (rst)
                base_q[p] <= '0;
            else if (wr_en && wr_col == slot_t'(p))
                base_q[p] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                bank_q[p] <= '0;
            else if (restore)
                bank_q[p] <= base_q[p];
            else if (rot_en)
                bank_q[p] <= bank_q[PV];
        end

        assign wt_bus[p*K*WW +: K*WW] = bank_q[p];

        p_rotate_r6: assert property (@(posedge clk) disable iff (rst)
            ($past(rot_en) && !$past(restore)) |->
                (wt_bus[p*K*WW +: K*WW] == $past(wt_bus[PV*K*WW +: K*WW])))
            else $error("p_rotate_r6");

        p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rot_en) && !$past(restore)) |->
                $stable(wt_bus[p*K*WW +: K*WW]))
            else $error("p_frozen_r7");
    end
endmodule

// File: rtl/sweep_feeder.sv
module sweep_feeder import sweep_feeder_pkg::*; #(
    parameter int DW   = 8,
    parameter int WW   = 8,
    parameter int AW   = 12,
    parameter int LW   = 8,
    parameter int STEP = K
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     row_base,
    input  logic [LW-1:0]     row_len,
    input  logic              last_row,
    output logic              fm_rd_en,
    output logic [AW-1:0]     fm_rd_addr,
    input  logic [K*DW-1:0]   fm_rd_data,
    input  logic              wt_wr_en,
    input  logic [PW-1:0]     wt_wr_col,
    input  logic [K*WW-1:0]   wt_wr_data,
    output logic              win_valid,
    output logic [PW-1:0]     win_head,
    output logic [K*K*DW-1:0] win_bus,
    output logic [K*K*WW-1:0] wt_bus,
    output logic              row_done,
    output logic              frame_done
);
    slot_t ptr;
    logic  load_en, rot_en, restore;

    feeder_ctrl #(.AW(AW), .LW(LW), .STEP(STEP)) u_ctrl (
        .clk, .rst, .start, .row_base, .row_len, .last_row,
        .rd_en(fm_rd_en), .rd_addr(fm_rd_addr), .ptr,
        .load_en, .rot_en, .restore,
        .valid(win_valid), .row_done, .frame_done
    );

    feeder_window #(.DW(DW)) u_window (
        .clk, .rst, .load_en, .load_slot(ptr),
        .col_data(fm_rd_data), .win_bus
    );

    feeder_wbank #(.WW(WW)) u_wbank (
        .clk, .rst, .wr_en(wt_wr_en), .wr_col(wt_wr_col),
        .wr_data(wt_wr_data), .restore, .rot_en, .wt_bus
    );

    assign win_head = ptr;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!win_valid && !fm_rd_en && !row_done && !frame_done))
        else $error("p_reset_quiet_r1");
endmodule

// File: tb/test_sweep_feeder.sv
module test_sweep_feeder;
    localparam int CLK_PERIOD = 10;
    localparam int K  = 5;
    localparam int DW = 8;
    localparam int WW = 8;
    localparam int AW = 12;
    localparam int LW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [AW-1:0]     row_base = '0;
    logic [LW-1:0]     row_len = '0;
    logic              last_row = 1'b0;
    logic              fm_rd_en;
    logic [AW-1:0]     fm_rd_addr;
    logic [K*DW-1:0]   fm_rd_data;
    logic              wt_wr_en = 1'b0;
    logic [2:0]        wt_wr_col = '0;
    logic [K*WW-1:0]   wt_wr_data = '0;
    logic              win_valid;
    logic [2:0]        win_head;
    logic [K*K*DW-1:0] win_bus;
    logic [K*K*WW-1:0] wt_bus;
    logic              row_done;
    logic              frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sweep_feeder i_sweep_feeder (
        .clk, .rst, .start, .row_base, .row_len, .last_row,
        .fm_rd_en, .fm_rd_addr, .fm_rd_data,
        .wt_wr_en, .wt_wr_col, .wt_wr_data,
        .win_valid, .win_head, .win_bus, .wt_bus, .row_done, .frame_done
    );

    logic [K*DW-1:0] mem [0:4095];
    assign fm_rd_data = mem[fm_rd_addr];

    function automatic logic [7:0] fmv(int s, int i, int c);
        return 8'((s * 37 + i * 11 + c * 7 + i * c + 3) & 255);
    endfunction

    function automatic logic [7:0] wval(int set, int i, int j);
        return 8'(((set * 13 + i * 5 + j * 3 + 1) ^ 8'h5A) & 255);
    endfunction

    typedef struct {
        int s;
        int c0;
        int wsel;
        bit last;
        bit flast;
    } win_item_t;

    win_item_t exp_q[$];
    int        addr_q[$];

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // read address monitor (R3)
    always @(negedge clk) begin
        if (!rst && fm_rd_en) begin
            if (addr_q.size() == 0) begin
                check(0, "R3", "unexpected read", fm_rd_addr, 0);
            end else begin
                int a;
                a = addr_q.pop_front();
                check(fm_rd_addr == AW'(a), "R3", "read address", fm_rd_addr, a);
            end
        end
    end

    // window scoreboard (R4 R5 R6 R9)
    logic [K*K*DW-1:0] prev_win;
    logic [2:0]        prev_head;
    bit                prev_valid = 1'b0;
    bit                prev_last = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!win_valid) begin
                check(!row_done && !frame_done, "R9", "done outside window",
                      {row_done, frame_done}, 0);
            end else if (exp_q.size() == 0) begin
                check(0, "R4", "unexpected window", win_head, 0);
            end else begin
                win_item_t it;
                int hexp, bad_x, bad_w;
                it = exp_q.pop_front();
                hexp = it.c0 % K;
                check(win_head == 3'(hexp), "R4", "win_head", win_head, hexp);
                bad_x = 0;
                bad_w = 0;
                for (int p = 0; p < K; p++) begin
                    int lc;
                    lc = (p - hexp + K) % K;
                    for (int i = 0; i < K; i++) begin
                        if (win_bus[(p*K+i)*DW +: DW] != fmv(it.s, i, it.c0 + lc)) bad_x++;
                        if (wt_bus[(p*K+i)*WW +: WW] != wval(it.wsel, i, lc)) bad_w++;
                    end
                end
                check(bad_x == 0, "R4", "window elements wrong", bad_x, 0);
                check(bad_w == 0, "R6 R7", "weight elements wrong", bad_w, 0);
                check(row_done == it.last, "R9", "row_done", row_done, it.last);
                check(frame_done == it.flast, "R9", "frame_done", frame_done, it.flast);
                if (prev_valid && !prev_last) begin
                    int bad_h;
                    bad_h = 0;
                    for (int p = 0; p < K; p++)
                        if (3'(p) != prev_head &&
                            win_bus[p*K*DW +: K*DW] != prev_win[p*K*DW +: K*DW]) bad_h++;
                    check(bad_h == 0, "R5", "retained slots changed", bad_h, 0);
                end
            end
            prev_valid = win_valid;
            prev_last  = row_done;
            prev_head  = win_head;
            prev_win   = win_bus;
        end
    end

    task automatic load_weights(int set);
        for (int j = 0; j < K; j++) begin
            wt_wr_en  = 1'b1;
            wt_wr_col = 3'(j);
            for (int i = 0; i < K; i++) wt_wr_data[i*WW +: WW] = wval(set, i, j);
            @(negedge clk);
        end
        wt_wr_en = 1'b0;
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic start_row(int s, int base, int len, int wsel, bit lastr, bit chain);
        if (chain) begin
            while (!row_done) @(negedge clk);
        end
        for (int k = 0; k < len - 4; k++) begin
            win_item_t it;
            it.s = s; it.c0 = k; it.wsel = wsel;
            it.last = (k == len - 5);
            it.flast = (k == len - 5) && lastr;
            exp_q.push_back(it);
        end
        for (int k = 0; k < len; k++) addr_q.push_back(base + 5 * k);
        start = 1'b1; row_base = AW'(base); row_len = LW'(len); last_row = lastr;
        @(negedge clk);
        start = 1'b0;
        if (chain)
            check(fm_rd_en && fm_rd_addr == AW'(base), "R10", "chained first read",
                  fm_rd_addr, base);
        for (int k = 0; k < K; k++) begin
            check(fm_rd_en && !win_valid, "R2", "fill cycle", {fm_rd_en, win_valid}, 2);
            @(negedge clk);
        end
        check(win_valid, "R2", "first window after fill", win_valid, 1);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(addr_q.size() == 0, "R3", "reads outstanding", addr_q.size(), 0);
    endtask

    initial begin
        int bases[4] = '{0, 200, 400, 600};
        for (int a = 0; a < 4096; a++) mem[a] = '0;
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 20; c++)
                for (int i = 0; i < K; i++)
                    mem[bases[s] + 5 * c][i*DW +: DW] = fmv(s, i, c);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        check(!win_valid && !fm_rd_en && !row_done && !frame_done, "R1", "reset outputs",
              {win_valid, fm_rd_en, row_done, frame_done}, 0);

        load_weights(0);
        // shortest row: a single window
        start_row(0, 0, 5, 0, 1'b0, 1'b0);
        wait_idle();

        // long row with a spurious start and weight writes in flight
        start_row(1, 200, 18, 0, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b1; row_base = AW'(900); row_len = LW'(6); last_row = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(win_valid && !(fm_rd_en && fm_rd_addr == AW'(900)), "R8",
              "start while busy", fm_rd_addr, 900);
        load_weights(1);

        // chained rows: new weights seen only from the next start
        start_row(2, 400, 9, 1, 1'b0, 1'b1);
        start_row(3, 600, 7, 1, 1'b1, 1'b1);
        wait_idle();
        check(!win_valid && !fm_rd_en, "R1", "idle after frame", {win_valid, fm_rd_en}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule